// File: doc/BRIEF.md
# Start-Stop Frame Aligner and Lock Detector

This block sits behind a clock-recovery stage that delivers one serial bit per clock. The stream carries 12-bit frames. Each frame is a start bit of 1, then ten payload bits, then a stop bit of 0. Because every frame ends in 0 and the next one opens with 1, a 0-to-1 transition marks the frame boundary. The block searches all twelve bit positions for that transition. It declares lock once one position holds steady, and it presents each recovered payload word with a one-cycle strobe.

Lock is refused while several positions in every frame carry persistent 0-to-1 transitions. Such a pattern could produce a false lock on a data pattern instead of the real boundary. Once the block is locked, the lock survives such patterns for as long as the locked boundary keeps arriving. Lock is dropped after a run of missing boundaries, and the hunt then restarts. A receive-enable blanks the word outputs but leaves the lock indication alone. A power-down input blanks everything and discards the lock.

Top module: `frame_aligner`

## Requirements
- R1: A frame is received as start bit 1, payload bits d0..d9 in arrival order, then stop bit 0. The recovered word carries d0 in bit 0 and d9 in bit 9.
- R2: `lock_n` is 0 when locked and 1 when searching. Lock is never reported before the boundary has been seen at one position in four consecutive frames. Starting from an idle all-zero line, a stream of clean frames brings `lock_n` to 0 within seven frames.
- R3: While locked, up to three consecutive frames without the locked boundary leave `lock_n` at 0. The fourth consecutive miss drops lock, and `lock_n` reads 1 within two further frames.
- R4: While searching, a stream in which two or more positions per frame carry a 0-to-1 transition frame after frame keeps `lock_n` at 1.
- R5: While locked, payloads that add extra 0-to-1 transitions at fixed positions (for example 10'h2AA) do not disturb lock, and they decode correctly.
- R6: While locked and enabled, `word_vld` pulses for exactly one cycle per frame, and `word_out` holds that frame's word. While `lock_n` is 1, `word_out` is 0 and `word_vld` is 0.
- R7: With `rx_en` low, `word_out` is 0 and `word_vld` stays 0 from the next cycle on, while `lock_n` still shows the true lock state. Raising `rx_en` resumes word delivery without relocking.
- R8: With `pwr_dn` high, `lock_n` is 1 and `word_out` and `word_vld` are 0 from the next cycle on, and all lock progress is cleared. After release, three clean frames are not enough to lock.
- R9: After reset, `lock_n` is 1, `word_out` is 0 and `word_vld` is 0.
- R10: Sync frames of six ones followed by six zeros have a single transition per frame. The block locks on them and decodes each one as 10'h01F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Power-down: blanks all outputs and clears lock |
| rx_en | input | 1 | Receive enable: low blanks word outputs |
| bit_in | input | 1 | Recovered serial bit |
| lock_n | output | 1 | Active-low lock indication |
| word_out | output | FRAME_LEN-2 | Recovered payload word, d0 in bit 0 |
| word_vld | output | 1 | One-cycle strobe per recovered word |

## Verification
The bench builds the block with its defaults: 12-bit frames, four frames to acquire and four misses to drop. With these values, acquisition, the hold through three missing boundaries and the drop on the fourth each happen within a few dozen bit times. That lets the bench step across each threshold frame by frame, bracketing it with one frame below and one frame past. A period-4 pattern keeps three positions consistent at once, so the search-time refusal can be shown directly. That same pattern then has to be flushed by sync frames before lock is gained.

// File: rtl/fal_pkg.sv
package fal_pkg;
  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } fal_state_e;
endpackage

// File: rtl/fal_window.sv
module fal_window #(
  parameter int DATA_W    = 10,
  parameter int FRAME_LEN = 12,
  parameter int PH_W      = 4
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              bit_in,
  output logic [DATA_W-1:0] sr,
  output logic [PH_W-1:0]   ph,
  output logic              rise
);
  // sr[0] is the newest bit; phase counts bit slots modulo the frame length
  always_ff @(posedge clk) begin
    if (clr) begin
      sr <= '0;
      ph <= '0;
    end else begin
      sr <= {sr[DATA_W-2:0], bit_in};
      ph <= (ph == PH_W'(FRAME_LEN-1)) ? '0 : ph + PH_W'(1);
    end
  end

  // a 0 followed by a 1 means a start bit just arrived
  assign rise = ~sr[1] & sr[0];

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (clr)
    ph < PH_W'(FRAME_LEN));
  // R1
  shift_order_chk: assert property (@(posedge clk) disable iff (clr)
    !$past(clr) |-> sr[1] == $past(sr[0]));
endmodule

// File: rtl/fal_hunter.sv
module fal_hunter #(
  parameter int FRAME_LEN   = 12,
  parameter int LOCK_FRAMES = 4,
  parameter int PH_W        = 4,
  parameter int CNT_W       = 3,
  parameter int NUM_W       = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [PH_W-1:0]  ph,
  input  logic             rise,
  output logic [NUM_W-1:0] full_n,
  output logic [NUM_W-1:0] near_n,
  output logic [PH_W-1:0]  full_pos
);
  logic [CNT_W-1:0] cnt [FRAME_LEN];

  for (genvar p = 0; p < FRAME_LEN; p++) begin : g_pos
    // consecutive frames with a transition at this slot, saturating
    always_ff @(posedge clk) begin
      if (clr) begin
        cnt[p] <= '0;
      end else if (ph == PH_W'(p)) begin
        if (!rise) begin
          cnt[p] <= '0;
        end else if (cnt[p] != CNT_W'(LOCK_FRAMES)) begin
          cnt[p] <= cnt[p] + CNT_W'(1);
        end
      end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (clr)
      cnt[p] <= CNT_W'(LOCK_FRAMES));
    // R2
    miss_clear_chk: assert property (@(posedge clk) disable iff (clr)
      (ph == PH_W'(p) && !rise) |=> cnt[p] == '0);
  end

  // full: stable long enough; near: one frame short (flags repetitive patterns)
  always_comb begin
    full_n   = '0;
    near_n   = '0;
    full_pos = '0;
    for (int p = 0; p < FRAME_LEN; p++) begin
      if (cnt[p] == CNT_W'(LOCK_FRAMES)) begin
        full_n   = full_n + NUM_W'(1);
        full_pos = PH_W'(p);
      end
      if (cnt[p] >= CNT_W'(LOCK_FRAMES-1)) begin
        near_n = near_n + NUM_W'(1);
      end
    end
  end
endmodule

// File: rtl/fal_lock_fsm.sv
module fal_lock_fsm
  import fal_pkg::*;
#(
  parameter int MISS_FRAMES = 4,
  parameter int PH_W        = 4,
  parameter int NUM_W       = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [PH_W-1:0]  ph,
  input  logic             rise,
  input  logic [NUM_W-1:0] full_n,
  input  logic [NUM_W-1:0] near_n,
  input  logic [PH_W-1:0]  full_pos,
  output logic             locked,
  output logic [PH_W-1:0]  lock_pos
);
  localparam int MISS_W = $clog2(MISS_FRAMES + 1);

  fal_state_e        state;
  logic [MISS_W-1:0] miss;

  always_ff @(posedge clk) begin
    if (clr) begin
      state    <= ST_HUNT;
      lock_pos <= '0;
      miss     <= '0;
    end else begin
      case (state)
        ST_HUNT: begin
          // decide once per frame, only for a single unrivalled candidate
          if (ph == '0 && full_n == NUM_W'(1) && near_n == NUM_W'(1)) begin
            state    <= ST_LOCKED;
            lock_pos <= full_pos;
            miss     <= '0;
          end
        end
        default: begin
          if (ph == lock_pos) begin
            if (rise) begin
              miss <= '0;
            end else if (miss == MISS_W'(MISS_FRAMES-1)) begin
              state <= ST_HUNT;
              miss  <= '0;
            end else begin
              miss <= miss + MISS_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign locked = (state == ST_LOCKED);

  // R4
  rmt_block_chk: assert property (@(posedge clk) disable iff (clr)
    (state == ST_HUNT && near_n > NUM_W'(1)) |=> state == ST_HUNT);
  // R3
  hold_on_hit_chk: assert property (@(posedge clk) disable iff (clr)
    (locked && ph == lock_pos && rise) |=> locked);
  // R2
  lock_entry_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(locked) |-> $past(full_n) == NUM_W'(1));
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner #(
  parameter int FRAME_LEN   = 12,
  parameter int LOCK_FRAMES = 4,
  parameter int MISS_FRAMES = 4,
  localparam int DATA_W     = FRAME_LEN - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_dn,
  input  logic              rx_en,
  input  logic              bit_in,
  output logic              lock_n,
  output logic [DATA_W-1:0] word_out,
  output logic              word_vld
);
  localparam int PH_W  = $clog2(FRAME_LEN);
  localparam int CNT_W = $clog2(LOCK_FRAMES + 1);
  localparam int NUM_W = $clog2(FRAME_LEN + 1);

  logic              clr;
  logic [DATA_W-1:0] sr;
  logic [PH_W-1:0]   ph;
  logic              rise;
  logic [NUM_W-1:0]  full_n;
  logic [NUM_W-1:0]  near_n;
  logic [PH_W-1:0]   full_pos;
  logic              locked;
  logic [PH_W-1:0]   lock_pos;
  logic [PH_W:0]     cap_sum;
  logic [PH_W:0]     cap_wrap;
  logic              cap;
  logic [DATA_W-1:0] word_nx;

  assign clr = rst | pwr_dn;

  fal_window #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .PH_W(PH_W)) u_window (
    .clk(clk), .clr(clr), .bit_in(bit_in), .sr(sr), .ph(ph), .rise(rise));

  fal_hunter #(.FRAME_LEN(FRAME_LEN), .LOCK_FRAMES(LOCK_FRAMES), .PH_W(PH_W),
               .CNT_W(CNT_W), .NUM_W(NUM_W)) u_hunter (
    .clk(clk), .clr(clr), .ph(ph), .rise(rise),
    .full_n(full_n), .near_n(near_n), .full_pos(full_pos));

  fal_lock_fsm #(.MISS_FRAMES(MISS_FRAMES), .PH_W(PH_W), .NUM_W(NUM_W)) u_fsm (
    .clk(clk), .clr(clr), .ph(ph), .rise(rise), .full_n(full_n),
    .near_n(near_n), .full_pos(full_pos), .locked(locked), .lock_pos(lock_pos));

  // the last payload bit is newest in the window DATA_W slots after the start bit
  assign cap_sum  = {1'b0, lock_pos} + (PH_W+1)'(DATA_W);
  assign cap_wrap = (cap_sum >= (PH_W+1)'(FRAME_LEN)) ? cap_sum - (PH_W+1)'(FRAME_LEN) : cap_sum;
  assign cap      = locked && (ph == cap_wrap[PH_W-1:0]);

  // first-arrived payload bit is oldest in the window and lands in bit 0
  for (genvar i = 0; i < DATA_W; i++) begin : g_word
    assign word_nx[i] = sr[DATA_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      lock_n   <= 1'b1;
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      lock_n   <= ~locked;
      word_vld <= cap & rx_en;
      if (!locked || !rx_en) begin
        word_out <= '0;
      end else if (cap) begin
        word_out <= word_nx;
      end
    end
  end

  // R8
  pwrdn_blank_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> (lock_n && !word_vld && word_out == '0));
  // R7
  rxen_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!word_vld && word_out == '0));
  // R6
  strobe_locked_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> !lock_n);
  // R6
  blank_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
    lock_n |-> (word_out == '0 && !word_vld));
endmodule

// File: tb/frame_aligner_bench.sv
`timescale 1ns/1ps
module frame_aligner_bench;
  localparam int NTBL = 8;
  localparam logic [9:0] DATA_TBL [NTBL] = '{10'h2AA, 10'h155, 10'h000, 10'h3FF,
                                            10'h001, 10'h200, 10'h0F0, 10'h2AA};
  localparam logic [9:0] SYNC_W = 10'h01F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_dn = 1'b0;
  logic       rx_en = 1'b1;
  logic       bit_in = 1'b0;
  logic       lock_n;
  logic [9:0] word_out;
  logic       word_vld;

  int         nchk = 0;
  int         nerr = 0;
  int         rxn = 0;
  logic [9:0] rxw [64];
  logic       watch = 1'b0;
  logic       saw_lock = 1'b0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  frame_aligner u_frame_aligner (
    .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .rx_en(rx_en), .bit_in(bit_in),
    .lock_n(lock_n), .word_out(word_out), .word_vld(word_vld));

  always @(negedge clk) begin
    if (!rst && word_vld && rxn < 64) begin
      rxw[rxn] = word_out;
      rxn = rxn + 1;
    end
    if (watch && !lock_n) saw_lock = 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b;
  endtask

  task automatic send_frame(input logic [9:0] w);
    send_bit(1'b1);
    for (int i = 0; i < 10; i++) send_bit(w[i]);
    send_bit(1'b0);
  endtask

  task automatic send_raw(input logic [11:0] v);
    for (int i = 11; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic send_sync(input int n);
    for (int i = 0; i < n; i++) send_frame(SYNC_W);
  endtask

  initial begin
    int start;
    // R9: reset state
    repeat (4) @(negedge clk);
    chk("R9 lock_n", 32'(lock_n), 32'd1);
    chk("R9 word_out", 32'(word_out), 32'd0);
    chk("R9 word_vld", 32'(word_vld), 32'd0);
    rst = 1'b0;
    send_zeros(24);

    // R2 / R10: acquisition on sync frames
    send_sync(3);
    chk("R2 no lock after 3 frames", 32'(lock_n), 32'd1);
    send_sync(4);
    chk("R2 locked after 7 frames", 32'(lock_n), 32'd0);
    rxn = 0;
    send_sync(2);
    chk("R10 sync words seen", 32'(rxn > 0), 32'd1);
    chk("R10 sync word value", 32'(rxw[rxn-1]), 32'(SYNC_W));

    // R1 / R5 / R6: table of words walked by one loop
    rxn = 0;
    for (int k = 0; k < NTBL; k++) send_frame(DATA_TBL[k]);
    send_sync(1);
    start = -1;
    for (int s = 0; s < rxn; s++) if (start < 0 && rxw[s] == DATA_TBL[0]) start = s;
    chk("R1 first table word found", 32'(start >= 0), 32'd1);
    if (start >= 0) begin
      for (int k = 0; k < NTBL; k++)
        chk("R1 R6 word per frame", 32'(rxw[start+k]), 32'(DATA_TBL[k]));
    end
    for (int k = 0; k < 6; k++) send_frame(10'h2AA);
    chk("R5 lock held through extra transitions", 32'(lock_n), 32'd0);

    // R7: receive-enable blanking
    rx_en = 1'b0;
    send_frame(10'h155);
    rxn = 0;
    send_frame(10'h155);
    send_frame(10'h155);
    chk("R7 no strobes while disabled", 32'(rxn), 32'd0);
    chk("R7 word_out blank", 32'(word_out), 32'd0);
    chk("R7 lock still shown", 32'(lock_n), 32'd0);
    rx_en = 1'b1;
    rxn = 0;
    for (int k = 0; k < 3; k++) send_frame(10'h0F0);
    chk("R7 delivery resumes", 32'(rxn >= 2), 32'd1);
    chk("R7 resumed word", 32'(rxw[rxn-1]), 32'h0F0);

    // R3 / R6: loss of lock on missing boundaries
    send_zeros(36);
    chk("R3 lock held after 3 misses", 32'(lock_n), 32'd0);
    send_zeros(36);
    chk("R3 lock dropped", 32'(lock_n), 32'd1);
    chk("R6 word_out blank when unlocked", 32'(word_out), 32'd0);
    chk("R6 word_vld low when unlocked", 32'(word_vld), 32'd0);

    // R4: repetitive multi-transition pattern refused
    saw_lock = 1'b0;
    watch = 1'b1;
    for (int k = 0; k < 20; k++) send_raw(12'b110011001100);
    watch = 1'b0;
    chk("R4 never locked on repetitive pattern", 32'(saw_lock), 32'd0);
    send_sync(8);
    chk("R4 locks once pattern gives way to sync", 32'(lock_n), 32'd0);

    // R8: power-down
    pwr_dn = 1'b1;
    send_sync(2);
    chk("R8 lock_n blank", 32'(lock_n), 32'd1);
    chk("R8 word_out blank", 32'(word_out), 32'd0);
    chk("R8 word_vld blank", 32'(word_vld), 32'd0);
    pwr_dn = 1'b0;
    send_sync(3);
    chk("R8 fresh acquisition needed", 32'(lock_n), 32'd1);
    send_sync(4);
    chk("R8 relock after release", 32'(lock_n), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule